// File: doc/BRIEF.md
# USB Packet Transmit Serializer

This block sits between a link-layer engine and the line driver of a USB device port. It takes bytes over an 8-bit valid/ready handshake and turns each packet into a serial stream of line symbols. Every packet opens with a generated SYNC field. Data bytes follow, least significant bit first. Stuff bits are inserted where long runs of ones occur. The stream is NRZI-encoded, and the packet closes with a generated end-of-packet (EOP) made of SE0 and then J.

Bit timing comes from an external one-clock-wide strobe, `bitStrobe`. The block moves to the next line symbol only on a clock edge where the strobe is high, so one design serves any bit rate that divides the clock. The engine ends a packet by keeping `txValid` low when the block asks for the next byte. This works at any byte boundary, including right after SYNC, and an EOP always follows. A test setting of the operating-mode input turns off stuff-bit insertion and leaves NRZI encoding active.

Top module: `usb_tx_serializer`

## Requirements
- R1: While `rst` is high, `busy` is 0, `se0Out` is 0, `lineOut` is 1 (the J level) and `txReady` is 0.
- R2: After `rst` falls, `txValid` is ignored for the first 5 rising clock edges. From the 6th edge on, an idle block with `txValid` high starts a packet on any edge where `bitStrobe` is high.
- R3: `lineOut`, `se0Out` and `busy` change only on edges where `bitStrobe` is high. The edge that starts a packet sets `busy` and holds the line at J. Each later strobe edge sends exactly one line symbol.
- R4: The first eight bits sent in a packet, before NRZI, are seven 0 bits followed by one 1 bit in time order.
- R5: Each data byte on `txByte[7:0]` is sent bit 0 first. NRZI keeps the line level for a 1 bit and toggles it for a 0 bit, starting from the J level 1.
- R6: `txReady` is high for exactly one clock. That clock is the strobe cycle in which the last bit of SYNC or of the current byte is sent, never a stuff-bit cycle. The byte on `txByte` is taken at that edge if `txValid` is high.
- R7: After six consecutive 1 bits, a 0 bit is inserted before anything else is sent and the run count restarts. The run counts across SYNC and byte boundaries and also applies after the last byte. The inserted bit is not a data bit.
- R8: With `opMode` equal to 2'b10, no stuff bits are inserted and NRZI still applies. The values 2'b00, 2'b01 and 2'b11 all insert stuff bits.
- R9: If `txValid` is low at a `txReady` edge, the next strobe after any pending stuff bit starts the EOP. This also holds when no byte has been taken. The EOP is two strobes of `se0Out` high, then one strobe of J with `se0Out` low. `busy` clears at the strobe edge after that.
- R10: While a packet is in flight, `txValid` and `txByte` have no effect outside `txReady` cycles.
- R11: While `busy` is low, `lineOut` is 1, `se0Out` is 0 and `txReady` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitStrobe | input | 1 | One-clock pulse per bit time |
| txByte | input | 8 | Byte offered by the link engine |
| txValid | input | 1 | Byte offered / packet continues |
| opMode | input | 2 | Operating mode; 2'b10 disables stuff bits |
| txReady | output | 1 | Byte taken at this edge when txValid is high |
| lineOut | output | 1 | NRZI-encoded line level (1 = J) |
| se0Out | output | 1 | Line driven to SE0 (EOP) |
| busy | output | 1 | Packet in progress |

## Verification
The checker watches several rules on every clock. It confirms that `txReady` is a single-cycle pulse inside a strobe cycle of an active packet, and that the outputs hold still between strobes. It also confirms that an idle line sits at J with no SE0, that the settle window after reset never starts a packet, that SE0 lasts at least two cycles and that SE0 hands over to J. The remaining rules need the bench's per-clock reference model, driven by packets chosen to create long runs of ones, trailing stuff bits, aborts right after SYNC and a valid signal that is high only in ready cycles. That model checks the exact bit order of SYNC and data, where stuff bits land and what the stuff-disable mode does, the precise cycle of each ready pulse, and that stray valid or byte values have no effect.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_EOP_SE0 = 2'd2,
    ST_EOP_J   = 2'd3
  } txState_t;

  // One-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadSync;   // start of packet: load SYNC into shifter
    logic loadByte;   // capture txByte into shifter
    logic emitData;   // send shifter bit 0 and shift
    logic emitStuff;  // send an inserted 0 bit
    logic startSe0;   // begin end-of-packet SE0
    logic emitJ;      // closing J bit of end-of-packet
  } dpCtrl_t;

endpackage

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int          DATA_W         = 8,
  parameter int          STUFF_LIMIT    = 6,
  parameter int          SETTLE_EDGES   = 5,
  parameter int          SE0_BITS       = 2,
  parameter logic [1:0]  STUFF_OFF_MODE = 2'b10
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitStrobe,
  input  logic     txValid,
  input  logic [1:0] opMode,
  input  logic     curBit,
  output dpCtrl_t  dpCtrl,
  output logic     txReady,
  output logic     busy
);

  localparam int IDX_W    = $clog2(DATA_W);
  localparam int RUN_W    = $clog2(STUFF_LIMIT + 1);
  localparam int SETTLE_W = $clog2(SETTLE_EDGES + 1);
  localparam int SE0_W    = $clog2(SE0_BITS) + 1;

  txState_t             state;
  logic                 haveBit;
  logic [IDX_W-1:0]     bitIdx;
  logic [RUN_W-1:0]     onesRun;
  logic [SE0_W-1:0]     se0Cnt;
  logic [SETTLE_W-1:0]  settleCnt;

  logic armed;
  logic stuffEn;
  logic stuffNow;
  logic lastBit;
  logic se0Last;

  assign armed    = (settleCnt == SETTLE_W'(SETTLE_EDGES));
  assign stuffEn  = (opMode != STUFF_OFF_MODE);
  assign stuffNow = stuffEn && (onesRun == RUN_W'(STUFF_LIMIT));
  assign lastBit  = (bitIdx == IDX_W'(DATA_W - 1));
  assign se0Last  = (se0Cnt == SE0_W'(SE0_BITS - 1));

  always_comb begin
    dpCtrl  = '0;
    txReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (bitStrobe && armed && txValid) dpCtrl.loadSync = 1'b1;
      end
      ST_ACTIVE: begin
        if (bitStrobe) begin
          if (stuffNow) begin
            dpCtrl.emitStuff = 1'b1;
          end else if (haveBit) begin
            dpCtrl.emitData = 1'b1;
            if (lastBit) begin
              txReady         = 1'b1;
              dpCtrl.loadByte = txValid;
            end
          end else begin
            dpCtrl.startSe0 = 1'b1;
          end
        end
      end
      ST_EOP_SE0: begin
        if (bitStrobe && se0Last) dpCtrl.emitJ = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      haveBit   <= 1'b0;
      bitIdx    <= '0;
      onesRun   <= '0;
      se0Cnt    <= '0;
      settleCnt <= '0;
    end else begin
      if (!armed) settleCnt <= settleCnt + 1'b1;

      if (dpCtrl.loadSync) begin
        state   <= ST_ACTIVE;
        haveBit <= 1'b1;
        bitIdx  <= '0;
        onesRun <= '0;
      end

      if (dpCtrl.emitStuff) onesRun <= '0;

      if (dpCtrl.emitData) begin
        if (!curBit)
          onesRun <= '0;
        else if (onesRun != RUN_W'(STUFF_LIMIT))
          onesRun <= onesRun + 1'b1;
        if (lastBit) begin
          bitIdx  <= '0;
          haveBit <= dpCtrl.loadByte;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end

      if (dpCtrl.startSe0) begin
        state  <= ST_EOP_SE0;
        se0Cnt <= '0;
      end

      if (state == ST_EOP_SE0 && bitStrobe && !se0Last) se0Cnt <= se0Cnt + 1'b1;
      if (dpCtrl.emitJ) state <= ST_EOP_J;
      if (state == ST_EOP_J && bitStrobe) state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/usb_tx_dpath.sv
module usb_tx_dpath
  import usb_tx_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] SYNC_PATTERN = {1'b1, {(DATA_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] txByte,
  output logic              curBit,
  output logic              lineOut,
  output logic              se0Out
);

  logic [DATA_W-1:0] shiftReg;
  logic              lineReg;
  logic              se0Reg;

  assign curBit  = shiftReg[0];
  assign lineOut = lineReg;
  assign se0Out  = se0Reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (dpCtrl.loadSync) begin
      shiftReg <= SYNC_PATTERN;
    end else if (dpCtrl.loadByte) begin
      shiftReg <= txByte;
    end else if (dpCtrl.emitData) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  // NRZI: a 0 bit (data or stuff) toggles the level, a 1 bit holds it.
  always_ff @(posedge clk) begin
    if (rst) begin
      lineReg <= 1'b1;
    end else if (dpCtrl.loadSync || dpCtrl.emitJ) begin
      lineReg <= 1'b1;
    end else if (dpCtrl.emitStuff || (dpCtrl.emitData && !curBit)) begin
      lineReg <= ~lineReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      se0Reg <= 1'b0;
    end else if (dpCtrl.startSe0) begin
      se0Reg <= 1'b1;
    end else if (dpCtrl.emitJ) begin
      se0Reg <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int         DATA_W         = 8,
  parameter int         STUFF_LIMIT    = 6,
  parameter int         SETTLE_EDGES   = 5,
  parameter int         SE0_BITS       = 2,
  parameter logic [1:0] STUFF_OFF_MODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitStrobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txValid,
  input  logic [1:0]        opMode,
  output logic              txReady,
  output logic              lineOut,
  output logic              se0Out,
  output logic              busy
);

  dpCtrl_t dpCtrl;
  logic    curBit;

  usb_tx_ctrl #(
    .DATA_W        (DATA_W),
    .STUFF_LIMIT   (STUFF_LIMIT),
    .SETTLE_EDGES  (SETTLE_EDGES),
    .SE0_BITS      (SE0_BITS),
    .STUFF_OFF_MODE(STUFF_OFF_MODE)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitStrobe(bitStrobe),
    .txValid  (txValid),
    .opMode   (opMode),
    .curBit   (curBit),
    .dpCtrl   (dpCtrl),
    .txReady  (txReady),
    .busy     (busy)
  );

  usb_tx_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .dpCtrl (dpCtrl),
    .txByte (txByte),
    .curBit (curBit),
    .lineOut(lineOut),
    .se0Out (se0Out)
  );

endmodule

// File: rtl/usb_tx_checker.sv
module usb_tx_checker #(
  parameter int SETTLE_EDGES = 5
) (
  input logic clk,
  input logic rst,
  input logic bitStrobe,
  input logic txReady,
  input logic lineOut,
  input logic se0Out,
  input logic busy
);

  localparam int CNT_W = $clog2(SETTLE_EDGES + 1);

  logic [CNT_W-1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != CNT_W'(SETTLE_EDGES)) sinceRst <= sinceRst + 1'b1;
  end

  assert_settle_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != CNT_W'(SETTLE_EDGES)) |=> !busy);

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    !bitStrobe |=> ($stable(lineOut) && $stable(se0Out) && $stable(busy)));

  assert_ready_in_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    txReady |-> (bitStrobe && busy && !se0Out));

  assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
    txReady |=> !txReady);

  assert_se0_min_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(se0Out) |=> se0Out);

  assert_eop_ends_j_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(se0Out) |-> (lineOut && busy));

  assert_idle_j_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (lineOut && !se0Out && !txReady));

endmodule

bind usb_tx_serializer usb_tx_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitStrobe(bitStrobe),
  .txReady  (txReady),
  .lineOut  (lineOut),
  .se0Out   (se0Out),
  .busy     (busy)
);

// File: tb/usb_tx_serializer_bench.sv
module usb_tx_serializer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitStrobe = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       txValid = 1'b0;
  logic [1:0] opMode = 2'b00;
  logic       txReady;
  logic       lineOut;
  logic       se0Out;
  logic       busy;

  always #2 clk = ~clk;

  usb_tx_serializer u_usb_tx_serializer (
    .clk      (clk),
    .rst      (rst),
    .bitStrobe(bitStrobe),
    .txByte   (txByte),
    .txValid  (txValid),
    .opMode   (opMode),
    .txReady  (txReady),
    .lineOut  (lineOut),
    .se0Out   (se0Out),
    .busy     (busy)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    edgesSinceRst = 0;
  bit    expLine = 1'b1;
  bit    expSe0 = 1'b0;
  bit    expBusy = 1'b0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  int    idx = -1;
  string curTest = "init";

  bit       symSe0[$];
  bit       symLevel[$];
  bit       symLast[$];
  bit [7:0] pktBytes[$];

  task automatic check(input string tag, input bit act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", tag, curTest, $time, act, exp);
    end
  endtask

  function automatic void pushSym(input bit s0, input bit lvl, input bit last);
    symSe0.push_back(s0);
    symLevel.push_back(lvl);
    symLast.push_back(last);
  endfunction

  // Expected symbol list: SYNC, bytes LSB first, stuffing, NRZI, EOP.
  function automatic void buildSyms(input bit stuffOn);
    bit lvl;
    int run;
    symSe0.delete();
    symLevel.delete();
    symLast.delete();
    lvl = 1'b1;
    run = 0;
    for (int u = 0; u <= pktBytes.size(); u++) begin
      bit [7:0] unitV;
      unitV = (u == 0) ? 8'h80 : pktBytes[u-1];
      for (int b = 0; b < 8; b++) begin
        if (!unitV[b]) lvl = ~lvl;
        pushSym(1'b0, lvl, b == 7);
        run = unitV[b] ? run + 1 : 0;
        if (stuffOn && run == 6) begin
          lvl = ~lvl;
          pushSym(1'b0, lvl, 1'b0);
          run = 0;
        end
      end
    end
    pushSym(1'b1, lvl, 1'b0);
    pushSym(1'b1, lvl, 1'b0);
    pushSym(1'b0, 1'b1, 1'b0);
  endfunction

  task automatic runCycle(input bit s, input bit v, input bit [7:0] d, output bit consumed);
    bit expReady;
    bit startNow;
    bitStrobe = s;
    txValid   = v;
    txByte    = d;
    expReady  = started && !done && s && (idx + 1 < symSe0.size()) && symLast[idx+1];
    startNow  = !started && !expBusy && s && v && (edgesSinceRst >= 5);
    #1;
    check(expBusy ? "R6 ready" : "R6 R11 ready", txReady, expReady);
    check(expBusy ? "R3 R9 busy" : "R2 R3 R11 busy", busy, expBusy);
    check("R9 R11 se0", se0Out, expSe0);
    if (!expSe0) check(expBusy ? "R4 R5 R7 R8 line" : "R11 line", lineOut, expLine);
    consumed = expReady && v;
    @(posedge clk);
    edgesSinceRst++;
    if (startNow) begin
      started = 1'b1;
      expBusy = 1'b1;
    end else if (started && !done && s) begin
      idx++;
      if (idx < symSe0.size()) begin
        expSe0  = symSe0[idx];
        expLine = symLevel[idx];
      end else begin
        expBusy = 1'b0;
        done    = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int period);
    bit c;
    for (int i = 0; i < n; i++) runCycle((i % period) == 0, 1'b0, 8'h00, c);
  endtask

  task automatic send(input int period, input bit [1:0] opm, input bit lazy);
    bit consumed;
    int bi;
    int cyc;
    int n;
    bi = 0;
    cyc = 0;
    n = pktBytes.size();
    opMode = opm;
    buildSyms(opm != 2'b10);
    started = 1'b0;
    done = 1'b0;
    idx = -1;
    while (!done && cyc < 20000) begin
      bit s, v, pred;
      bit [7:0] d;
      s = (cyc % period) == 0;
      pred = started && s && (idx + 1 < symSe0.size()) && symLast[idx+1];
      if (!started) v = 1'b1;
      else if (lazy) v = pred && (bi < n);
      else v = (bi < n);
      if (bi < n && (v || !lazy)) d = pktBytes[bi];
      else d = 8'(cyc * 37 + 5);
      runCycle(s, v, d, consumed);
      if (consumed) bi++;
      cyc++;
    end
    compared++;
    if (!done || bi != n) begin
      mismatched++;
      $display("FAIL R9 R6 [%s] packet end: actual done=%0b bytes=%0d expected done=1 bytes=%0d",
               curTest, done, bi, n);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    bitStrobe = 1'b0;
    txValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    curTest = "R1 reset state";
    check("R1 busy", busy, 1'b0);
    check("R1 se0", se0Out, 1'b0);
    check("R1 line", lineOut, 1'b1);
    check("R1 ready", txReady, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    edgesSinceRst = 0;
    expLine = 1'b1;
    expSe0 = 1'b0;
    expBusy = 1'b0;
    started = 1'b0;
    done = 1'b0;
    idx = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    doReset();

    curTest = "R2 settle window, strobe every clock";
    pktBytes = '{8'h5A};
    send(1, 2'b00, 1'b0);
    idle(6, 1);

    curTest = "R4 R5 R6 two bytes";
    pktBytes = '{8'hA5, 8'h3C};
    send(3, 2'b00, 1'b0);
    idle(5, 3);

    curTest = "R7 long ones with trailing stuff";
    pktBytes = '{8'hFF, 8'hFF, 8'hFC};
    send(2, 2'b00, 1'b0);
    idle(4, 2);

    curTest = "R8 stuffing disabled";
    pktBytes = '{8'hFF, 8'hFF};
    send(2, 2'b10, 1'b0);
    idle(4, 2);

    curTest = "R8 mode 11 still stuffs";
    pktBytes = '{8'hFF, 8'h7F};
    send(1, 2'b11, 1'b0);

    curTest = "R8 mode 01 still stuffs";
    pktBytes = '{8'hFE, 8'hFF};
    send(2, 2'b01, 1'b0);
    idle(3, 1);

    curTest = "R9 abort right after SYNC";
    pktBytes.delete();
    send(2, 2'b00, 1'b0);
    idle(3, 2);

    curTest = "R9 abort after one byte";
    pktBytes = '{8'hC3};
    send(3, 2'b00, 1'b0);

    curTest = "R10 valid only in ready cycles";
    pktBytes = '{8'h00, 8'h81, 8'hFE};
    send(3, 2'b00, 1'b1);

    curTest = "R3 back to back, strobe every clock";
    pktBytes = '{8'h12, 8'h34, 8'h56};
    send(1, 2'b00, 1'b0);
    pktBytes = '{8'hFF};
    send(1, 2'b00, 1'b0);
    idle(4, 1);

    doReset();
    curTest = "R2 settle window, slow strobe";
    pktBytes = '{8'h96};
    send(2, 2'b00, 1'b0);
    idle(4, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule